// File: doc/BRIEF.md
# Sleep-Time Wakeup Pin Monitor

This block watches a configurable set of external pins while the rest of the chip is asleep. It sits in an always-on domain. Each pin has its own enable bit and a choice of trigger: a rising edge, a falling edge, both edges, or a level whose sense is chosen per pin. While the sleep input is high, any enabled pin that meets its condition sets a sticky bit in the status bank. The block then raises a single registered wake output.

Software configures the pins through a small word-addressed register bus before it enters sleep, and it clears status by writing zero. After wakeup it reads the status words together with the enable words to find which pins caused the wake. Pins are packed 32 to a word. Every configuration bank therefore holds ceil(NUM_PINS/32) words. Two timer words at the bottom of the map are plain read/write storage.

Top module: `wake_monitor`

## Requirements
- R1: After reset every timer word and every bank word read as zero, and `wake` is low.
- R2: The byte address of timer word 0 is 0x00 and of timer word 1 is 0x04. Word i of bank b sits at byte address (b*n + i + 2)*4, where n = ceil(NUM_PINS/32). The banks are b=0 enable, b=1 falling edge, b=2 rising edge, b=3 polarity and b=4 status. Each of these words reads back what was last written to it.
- R3: Pin p maps to bit (p mod 32) of word (p/32) in every bank. Bits that belong to no pin always read zero.
- R4: An enabled pin with its rising bit set records a status bit on a synchronised low-to-high transition during sleep.
- R5: An enabled pin with its falling bit set records a status bit on a high-to-low transition during sleep. With both bits set, either transition records it.
- R6: When both edge bits of an enabled pin are clear, the pin is level sensitive. It records status while it equals its polarity bit (1 means active high, 0 means active low).
- R7: A pin whose enable bit is clear never sets its status bit and never causes a wake.
- R8: Detection happens only while `sleep` is high. A pin that is already high when sleep starts produces no rising-edge event.
- R9: Status bits are sticky. They stay set after the pin condition ends and after sleep ends, until the status word is written. Writing zero clears them.
- R10: `wake` is the OR of all status bits ANDed with their enable bits, delayed by one register. Clearing the enable bit of a recorded pin drops `wake`.
- R11: Reads of any word address beyond the last status word return zero. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | High while the system is asleep; gates detection |
| pins | input | NUM_PINS | Asynchronous wakeup pin inputs |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| wake | output | 1 | Registered wake request |

## Verification
The assertions assume that the pins and `sleep` change only once the previous value has settled through the synchroniser, and that a status write is never issued in the same cycle that a pin event is recorded. The stimulus changes pins and `sleep` only between clock edges and waits several cycles after each change. It issues status clears only while no configured pin is moving. The stimulus also keeps every unused pin's enable bit clear, so active-low level detection on idle low pins cannot set stray status bits.

// File: rtl/wake_monitor.sv
module wake_monitor #(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep,
  input  logic [NUM_PINS-1:0] pins,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic                wake
);
  localparam int unsigned NW    = (NUM_PINS + 31) / 32;
  localparam int unsigned NB    = NW * 32;
  localparam int unsigned LASTW = 5 * NW + 2;

  logic [31:0] tmr0, tmr1;
  logic [NB-1:0] en_q, fall_q, rise_q, pol_q, stat_q, stat_nx;
  logic [NUM_PINS-1:0] s1, s2, prev;
  logic [NB-1:0] pmask, cur, old, rise_ev, fall_ev, lvl_hit, trig;

  logic [ADDR_W-3:0] widx;
  int unsigned koff, bsel, wsel;
  logic is_t0, is_t1, in_bank, st_wr;

  always_comb begin
    for (int i = 0; i < int'(NB); i++) pmask[i] = (i < NUM_PINS);
  end

  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    koff    = 32'(widx) - 32'd2;
    is_t0   = (32'(widx) == 32'd0);
    is_t1   = (32'(widx) == 32'd1);
    in_bank = (32'(widx) >= 32'd2) && (32'(widx) < LASTW);
    bsel    = koff / NW;
    wsel    = koff % NW;
  end

  assign st_wr = wr_en && in_bank && (bsel == 32'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= pins;
      s2   <= s1;
      prev <= s2;
    end
  end

  always_comb begin
    cur = '0;
    old = '0;
    cur[NUM_PINS-1:0] = s2;
    old[NUM_PINS-1:0] = prev;
  end

  assign rise_ev = cur & ~old;
  assign fall_ev = ~cur & old;
  assign lvl_hit = ~rise_q & ~fall_q & ~(cur ^ pol_q);
  assign trig    = en_q & pmask & ((rise_q & rise_ev) | (fall_q & fall_ev) | lvl_hit);

  always_comb begin
    stat_nx = stat_q;
    if (st_wr) stat_nx[wsel*32 +: 32] = wdata;
    if (sleep) stat_nx = stat_nx | trig;
    stat_nx = stat_nx & pmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr0   <= '0;
      tmr1   <= '0;
      en_q   <= '0;
      fall_q <= '0;
      rise_q <= '0;
      pol_q  <= '0;
      stat_q <= '0;
      wake   <= 1'b0;
    end else begin
      if (wr_en && is_t0) tmr0 <= wdata;
      if (wr_en && is_t1) tmr1 <= wdata;
      if (wr_en && in_bank) begin
        case (bsel)
          32'd0:   en_q[wsel*32 +: 32]   <= wdata & pmask[wsel*32 +: 32];
          32'd1:   fall_q[wsel*32 +: 32] <= wdata & pmask[wsel*32 +: 32];
          32'd2:   rise_q[wsel*32 +: 32] <= wdata & pmask[wsel*32 +: 32];
          32'd3:   pol_q[wsel*32 +: 32]  <= wdata & pmask[wsel*32 +: 32];
          default: ;
        endcase
      end
      stat_q <= stat_nx;
      wake   <= |(stat_q & en_q);
    end
  end

  always_comb begin
    rdata = '0;
    if (is_t0) rdata = tmr0;
    else if (is_t1) rdata = tmr1;
    else if (in_bank) begin
      case (bsel)
        32'd0:   rdata = en_q[wsel*32 +: 32];
        32'd1:   rdata = fall_q[wsel*32 +: 32];
        32'd2:   rdata = rise_q[wsel*32 +: 32];
        32'd3:   rdata = pol_q[wsel*32 +: 32];
        default: rdata = stat_q[wsel*32 +: 32];
      endcase
    end
  end

  p_hold_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !st_wr) |=> $stable(stat_q));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !st_wr) |=> (($past(stat_q) & ~stat_q) == '0));

  p_no_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

  p_oor_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_t0 && !is_t1 && !in_bank) |-> (rdata == '0));

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q | stat_q | rise_q | fall_q | pol_q) & ~pmask) == '0);

  p_quiet_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) == '0) |=> !wake);
endmodule

// File: tb/tb_wake_monitor.sv
`timescale 1ns/1ps
module tb_wake_monitor;
  localparam int NP = 40;
  logic clk = 0, rst_n = 0, sleep = 0, wr_en = 0, wake;
  logic [NP-1:0] pins = '0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int total = 0, bad = 0;

  localparam logic [7:0] EN0 = 8'h08, EN1 = 8'h0C, FA0 = 8'h10, FA1 = 8'h14,
    RI0 = 8'h18, RI1 = 8'h1C, PO0 = 8'h20, PO1 = 8'h24, ST0 = 8'h28, ST1 = 8'h2C;

  wake_monitor #(.NUM_PINS(NP), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .pins(pins), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wake(wake));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    sleep = 0; pins = '0;
    idle(4);
    for (int a = 8; a <= 8'h2C; a += 4) wr(8'(a), 32'h0);
    idle(2);
  endtask

  task automatic t_reset();
    for (int a = 0; a <= 8'h2C; a += 4) rd("R1 reset word", 8'(a), 32'h0);
    chk("R1 reset wake", {31'b0, wake}, 32'h0);
  endtask

  task automatic t_map();
    wr(8'h00, 32'hDEADBEEF); wr(8'h04, 32'h12345678);
    for (int a = 8; a <= 8'h2C; a += 8) wr(8'(a), 32'hA5A50000 | 32'(a));
    for (int a = 8'h0C; a <= 8'h2C; a += 8) wr(8'(a), 32'hFFFFFFFF);
    rd("R2 timer0", 8'h00, 32'hDEADBEEF);
    rd("R2 timer1", 8'h04, 32'h12345678);
    for (int a = 8; a <= 8'h2C; a += 8) rd("R2 bank word0", 8'(a), 32'hA5A50000 | 32'(a));
    for (int a = 8'h0C; a <= 8'h2C; a += 8) rd("R3 pad bits word1", 8'(a), 32'h000000FF);
    wr(8'h00, 0); wr(8'h04, 0);
    clear_all();
  endtask

  task automatic t_rise();
    wr(EN0, 32'h20); wr(RI0, 32'h20);
    sleep = 1; idle(3);
    rd("R4 no early status", ST0, 32'h0);
    pins[5] = 1; idle(5);
    rd("R4 rising pin5", ST0, 32'h20);
    chk("R10 wake after rise", {31'b0, wake}, 32'h1);
    pins[5] = 0; sleep = 0; idle(4);
    rd("R9 sticky after sleep", ST0, 32'h20);
    wr(ST0, 0); idle(2);
    rd("R9 clear by zero", ST0, 32'h0);
    chk("R10 wake drops after clear", {31'b0, wake}, 32'h0);
    clear_all();
  endtask

  task automatic t_fall();
    pins[37] = 1; idle(4);
    wr(EN1, 32'h20); wr(FA1, 32'h20);
    sleep = 1; idle(4);
    rd("R5 no status while high", ST1, 32'h0);
    pins[37] = 0; idle(5);
    rd("R5 falling pin37 word1 bit5 (R3)", ST1, 32'h20);
    clear_all();
    wr(EN0, 32'h4); wr(RI0, 32'h4); wr(FA0, 32'h4);
    sleep = 1; idle(3);
    pins[2] = 1; idle(5);
    rd("R5 both edges, rise", ST0, 32'h4);
    wr(ST0, 0); idle(2);
    rd("R5 both edges, cleared", ST0, 32'h0);
    pins[2] = 0; idle(5);
    rd("R5 both edges, fall", ST0, 32'h4);
    clear_all();
  endtask

  task automatic t_level();
    wr(EN1, 32'h8); wr(PO1, 32'h8);
    sleep = 1; idle(4);
    rd("R6 active high idle", ST1, 32'h0);
    pins[35] = 1; idle(5);
    rd("R6 active high pin35", ST1, 32'h8);
    clear_all();
    wr(EN0, 32'h40);
    sleep = 1; idle(4);
    rd("R6 active low pin6", ST0, 32'h40);
    clear_all();
  endtask

  task automatic t_disabled();
    wr(RI0, 32'h100);
    sleep = 1; idle(3);
    pins[8] = 1; idle(3); pins[8] = 0; idle(5);
    rd("R7 disabled pin8", ST0, 32'h0);
    chk("R7 no wake", {31'b0, wake}, 32'h0);
    clear_all();
    wr(EN0, 32'h200); wr(RI0, 32'h200);
    sleep = 1; idle(3);
    pins[9] = 1; idle(5);
    chk("R10 wake set pin9", {31'b0, wake}, 32'h1);
    wr(EN0, 0); idle(2);
    chk("R10 wake drops on enable clear", {31'b0, wake}, 32'h0);
    rd("R10 status kept", ST0, 32'h200);
    clear_all();
  endtask

  task automatic t_awake();
    wr(EN0, 32'h400); wr(RI0, 32'h400);
    idle(2);
    pins[10] = 1; idle(5);
    rd("R8 no detect awake", ST0, 32'h0);
    sleep = 1; idle(6);
    rd("R8 no spurious edge at sleep start", ST0, 32'h0);
    chk("R8 no wake", {31'b0, wake}, 32'h0);
    clear_all();
  endtask

  task automatic t_oor();
    wr(8'h30, 32'hFFFFFFFF); wr(8'hFC, 32'hFFFFFFFF);
    rd("R11 read 0x30", 8'h30, 32'h0);
    rd("R11 read 0xFC", 8'hFC, 32'h0);
    for (int a = 0; a <= 8'h2C; a += 4) rd("R11 map untouched", 8'(a), 32'h0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_level();
    t_disabled();
    t_awake();
    t_oor();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule